// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Sequencer

This block is the front end of a small processor core. It reads instruction bytes one at a time over a program-memory port of its own, which has its own address and data lines and shares nothing with the register or data-RAM buses. From the first byte it finds the instruction's format and length, and it collects the one or two bytes that may follow. It then presents a decoded bundle for one cycle. The bundle holds the opcode, an immediate or address operand, a 16-bit wide operand or a 12-bit signed relative offset, together with the address of the instruction, the sequential next address and the relative branch target.

The length of an instruction is not always aligned to a whole opcode byte. In the short jump/call format a 4-bit opcode sits in the upper nibble of the first byte, and the lower nibble becomes the top of a 12-bit two's-complement offset that continues into the second byte. The other formats use a full 8-bit opcode. The execution side keeps control of the flow of the program: it asserts a branch-take input while the bundle is presented. It can also freeze the whole sequencer with a stall input.

Top module: `instr_fetch_seq`

## Requirements
- R1: While reset is low, and after reset is released, the fetch address is 0x0000, no bundle is valid, and the sequencer waits for a first byte, with the read strobe high unless stalled.
- R2: The first byte selects the format code and the length. If its upper nibble is 8 to F, the format is relative (code 3, 2 bytes). Otherwise, 0x40 to 0x4F is wide (code 4, 3 bytes), 0x10 to 0x1F is immediate (code 1, 2 bytes), 0x20 to 0x3F is address (code 2, 2 bytes), and every other value is single (code 0, 1 byte).
- R3: Each byte is accepted in a cycle where the read strobe and memory-valid are both high. Successive accepted bytes come from consecutive fetch addresses, wrapping modulo 2^16.
- R4: `instr_valid` goes high in the cycle after the last byte of an instruction is accepted. It stays high for exactly one cycle when there is no stall. `instr_pc` then equals the address of the first byte.
- R5: The opcode output is the whole first byte. The operand is {0x00, byte1} for the immediate and address formats, {byte1, byte2} for the wide format, and zero otherwise. The offset is {byte0[3:0], byte1} for the relative format and zero otherwise.
- R6: `instr_next_pc` equals `instr_pc` plus the length, modulo 2^16. While a bundle is presented, the fetch address already equals this value.
- R7: `instr_target` equals `instr_pc` plus the sign-extended 12-bit offset, modulo 2^16. If `take_branch` is high during an unstalled valid cycle of a relative instruction, fetching resumes at that target.
- R8: `take_branch` has no effect on a non-relative instruction: fetching resumes at `instr_next_pc`.
- R9: While `stall` is high, the read strobe is low and the fetch address does not change. A bundle that is being presented stays valid and unchanged.
- R10: A cycle with the read strobe high and memory-valid low accepts nothing and leaves the fetch address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Freeze the sequencer and the fetch address |
| take_branch | input | 1 | Redirect to the relative target while a relative bundle is valid |
| mem_data | input | 8 | Program-memory byte at `mem_addr` |
| mem_valid | input | 1 | `mem_data` is valid this cycle |
| mem_addr | output | 16 | Program-memory fetch address |
| mem_rd | output | 1 | Read strobe |
| instr_valid | output | 1 | Decoded bundle is valid |
| instr_fmt | output | 3 | Format code (0 single, 1 immediate, 2 address, 3 relative, 4 wide) |
| instr_len | output | 2 | Instruction length in bytes |
| instr_opcode | output | 8 | First instruction byte |
| instr_operand | output | 16 | Immediate, address or wide operand |
| instr_offset | output | 12 | Signed relative offset |
| instr_pc | output | 16 | Address of the first byte |
| instr_next_pc | output | 16 | Sequential next address |
| instr_target | output | 16 | Relative branch target |

## Verification
The assertions check several properties on every cycle. Each accepted byte moves the fetch address on by one, and a wait or stall cycle holds it. A valid bundle lasts one cycle unless stalled. The fetch address while a bundle is presented equals the sequential next address, and after the valid cycle it equals either the target or the next address, depending on the branch-take input and the format. A single byte and a length of one always go together. Only the bench's scenarios can show that every first-byte value gets the correct format, length and field extraction. The bench sweeps all 256 first bytes with irregular memory-valid gaps and with branch-take both set and clear. It also covers the computed offsets that wrap, a stall in the middle of an instruction, and a reset in the middle of an instruction.

// File: rtl/ifs_pkg.sv
package ifs_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam int OFS_W  = NIB_W + BYTE_W;

  typedef enum logic [2:0] {
    FMT_SINGLE = 3'd0,
    FMT_IMM    = 3'd1,
    FMT_ADDR   = 3'd2,
    FMT_REL    = 3'd3,
    FMT_WIDE   = 3'd4
  } fmt_e;

  typedef enum logic [1:0] {
    ST_FIRST = 2'd0,
    ST_REST  = 2'd1,
    ST_DONE  = 2'd2
  } seq_st_e;
endpackage

// File: rtl/ifs_classify.sv
module ifs_classify
  import ifs_pkg::*;
#(
  parameter logic [15:0]  REL_NIBS = 16'hFF00,
  parameter logic [255:0] WIDE_MAP = {176'b0, 16'hFFFF, 64'b0},
  parameter logic [255:0] IMM_MAP  = {224'b0, 16'hFFFF, 16'b0},
  parameter logic [255:0] ADR_MAP  = {192'b0, 32'hFFFF_FFFF, 32'b0}
) (
  input  logic [BYTE_W-1:0] first_byte,
  output fmt_e              fmt,
  output logic [1:0]        len
);
  // Relative format claims its whole nibble group first; then 8-bit opcodes.
  always_comb begin
    fmt = FMT_SINGLE;
    len = 2'd1;
    if (REL_NIBS[first_byte[BYTE_W-1 -: NIB_W]]) begin
      fmt = FMT_REL;
      len = 2'd2;
    end else if (WIDE_MAP[first_byte]) begin
      fmt = FMT_WIDE;
      len = 2'd3;
    end else if (IMM_MAP[first_byte]) begin
      fmt = FMT_IMM;
      len = 2'd2;
    end else if (ADR_MAP[first_byte]) begin
      fmt = FMT_ADDR;
      len = 2'd2;
    end
  end
endmodule

// File: rtl/ifs_assemble.sv
module ifs_assemble
  import ifs_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int MAX_LEN = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [MAX_LEN-1:0]             wr_sel,
  input  logic [BYTE_W-1:0]              byte_in,
  input  logic [ADDR_W-1:0]              pc_in,
  input  fmt_e                           fmt_in,
  input  logic [1:0]                     len_in,
  output logic [MAX_LEN-1:0][BYTE_W-1:0] slots,
  output logic [ADDR_W-1:0]              start_pc,
  output fmt_e                           fmt_q,
  output logic [1:0]                     len_q
);
  // One byte register per instruction position.
  for (genvar i = 0; i < MAX_LEN; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slots[i] <= '0;
      end else if (wr_sel[i]) begin
        slots[i] <= byte_in;
      end
    end
  end

  // Format, length and start address are captured with the first byte.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_pc <= '0;
      fmt_q    <= FMT_SINGLE;
      len_q    <= 2'd1;
    end else if (wr_sel[0]) begin
      start_pc <= pc_in;
      fmt_q    <= fmt_in;
      len_q    <= len_in;
    end
  end
endmodule

// File: rtl/ifs_pc_unit.sv
module ifs_pc_unit
  import ifs_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic              load,
  input  logic [ADDR_W-1:0] base_pc,
  input  logic [OFS_W-1:0]  offset,
  input  logic [1:0]        len,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] next_pc,
  output logic [ADDR_W-1:0] target
);
  localparam int EXT_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0] pc_d;
  logic              pc_en;

  assign target  = base_pc + {{EXT_W{offset[OFS_W-1]}}, offset};
  assign next_pc = base_pc + ADDR_W'(len);

  always_comb begin
    pc_en = advance | load;
    pc_d  = pc_q;
    if (load) begin
      pc_d = target;
    end else if (advance) begin
      pc_d = pc_q + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end
endmodule

// File: rtl/instr_fetch_seq.sv
module instr_fetch_seq
  import ifs_pkg::*;
#(
  parameter int           ADDR_W   = 16,
  parameter logic [15:0]  REL_NIBS = 16'hFF00,
  parameter logic [255:0] WIDE_MAP = {176'b0, 16'hFFFF, 64'b0},
  parameter logic [255:0] IMM_MAP  = {224'b0, 16'hFFFF, 16'b0},
  parameter logic [255:0] ADR_MAP  = {192'b0, 32'hFFFF_FFFF, 32'b0}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stall,
  input  logic                take_branch,
  input  logic [7:0]          mem_data,
  input  logic                mem_valid,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_rd,
  output logic                instr_valid,
  output logic [2:0]          instr_fmt,
  output logic [1:0]          instr_len,
  output logic [7:0]          instr_opcode,
  output logic [15:0]         instr_operand,
  output logic [11:0]         instr_offset,
  output logic [ADDR_W-1:0]   instr_pc,
  output logic [ADDR_W-1:0]   instr_next_pc,
  output logic [ADDR_W-1:0]   instr_target
);
  localparam int MAX_LEN = 3;
  localparam int IDX_W   = $clog2(MAX_LEN);

  seq_st_e                        state_q, state_d;
  logic [IDX_W-1:0]               idx_q, idx_d;
  logic                           accept;
  logic                           branch_load;
  logic [MAX_LEN-1:0]             wr_sel;
  fmt_e                           dec_fmt, fmt_q;
  logic [1:0]                     dec_len, len_q;
  logic [MAX_LEN-1:0][BYTE_W-1:0] slots;
  logic [ADDR_W-1:0]              pc_q, start_pc;
  logic [OFS_W-1:0]               offset;

  ifs_classify #(
    .REL_NIBS (REL_NIBS),
    .WIDE_MAP (WIDE_MAP),
    .IMM_MAP  (IMM_MAP),
    .ADR_MAP  (ADR_MAP)
  ) u_classify (
    .first_byte (mem_data),
    .fmt        (dec_fmt),
    .len        (dec_len)
  );

  // Next-state logic of the byte-collection sequencer.
  always_comb begin
    state_d     = state_q;
    idx_d       = idx_q;
    branch_load = 1'b0;
    mem_rd      = (state_q != ST_DONE) && !stall;
    accept      = mem_rd && mem_valid;
    unique case (state_q)
      ST_FIRST: begin
        if (accept) begin
          if (dec_len == 2'd1) begin
            state_d = ST_DONE;
          end else begin
            state_d = ST_REST;
            idx_d   = IDX_W'(1);
          end
        end
      end
      ST_REST: begin
        if (accept) begin
          if (idx_q == IDX_W'(len_q - 2'd1)) begin
            state_d = ST_DONE;
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end
      end
      ST_DONE: begin
        if (!stall) begin
          state_d     = ST_FIRST;
          branch_load = take_branch && (fmt_q == FMT_REL);
        end
      end
      default: state_d = ST_FIRST;
    endcase
    for (int i = 0; i < MAX_LEN; i++) begin
      wr_sel[i] = accept &&
                  (((state_q == ST_FIRST) && (i == 0)) ||
                   ((state_q == ST_REST) && (idx_q == IDX_W'(i))));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FIRST;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  ifs_assemble #(
    .ADDR_W  (ADDR_W),
    .MAX_LEN (MAX_LEN)
  ) u_assemble (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_sel   (wr_sel),
    .byte_in  (mem_data),
    .pc_in    (pc_q),
    .fmt_in   (dec_fmt),
    .len_in   (dec_len),
    .slots    (slots),
    .start_pc (start_pc),
    .fmt_q    (fmt_q),
    .len_q    (len_q)
  );

  ifs_pc_unit #(
    .ADDR_W (ADDR_W)
  ) u_pc (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (accept),
    .load    (branch_load),
    .base_pc (start_pc),
    .offset  (offset),
    .len     (len_q),
    .pc_q    (pc_q),
    .next_pc (instr_next_pc),
    .target  (instr_target)
  );

  // Field extraction for the presented bundle.
  always_comb begin
    offset        = '0;
    instr_operand = '0;
    unique case (fmt_q)
      FMT_IMM, FMT_ADDR: instr_operand = {{BYTE_W{1'b0}}, slots[1]};
      FMT_WIDE:          instr_operand = {slots[1], slots[2]};
      FMT_REL:           offset        = {slots[0][NIB_W-1:0], slots[1]};
      default:           instr_operand = '0;
    endcase
  end

  assign mem_addr     = pc_q;
  assign instr_valid  = (state_q == ST_DONE);
  assign instr_fmt    = fmt_q;
  assign instr_len    = len_q;
  assign instr_opcode = slots[0];
  assign instr_offset = offset;
  assign instr_pc     = start_pc;
endmodule

// File: rtl/ifs_checker.sv
module ifs_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stall,
  input logic              take_branch,
  input logic              mem_valid,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              instr_valid,
  input logic [2:0]        instr_fmt,
  input logic [1:0]        instr_len,
  input logic [ADDR_W-1:0] instr_next_pc,
  input logic [ADDR_W-1:0] instr_target
);
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_valid) |=> (mem_addr == ADDR_W'($past(mem_addr) + ADDR_W'(1))));

  p_wait_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_valid) |=> $stable(mem_addr));

  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !stall) |=> !instr_valid);

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(mem_addr) && $stable(instr_valid)));

  p_single_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |-> ((instr_fmt == 3'd0) == (instr_len == 2'd1)));

  p_fetch_at_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |-> (mem_addr == instr_next_pc));

  p_branch_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !stall && take_branch && instr_fmt == 3'd3)
      |=> (mem_addr == $past(instr_target)));

  p_branch_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !stall && !(take_branch && instr_fmt == 3'd3))
      |=> (mem_addr == $past(instr_next_pc)));
endmodule

bind instr_fetch_seq ifs_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .stall         (stall),
  .take_branch   (take_branch),
  .mem_valid     (mem_valid),
  .mem_rd        (mem_rd),
  .mem_addr      (mem_addr),
  .instr_valid   (instr_valid),
  .instr_fmt     (instr_fmt),
  .instr_len     (instr_len),
  .instr_next_pc (instr_next_pc),
  .instr_target  (instr_target)
);

// File: tb/sim_instr_fetch_seq.sv
`timescale 1ns/1ps
module sim_instr_fetch_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        stall;
  logic        take_branch;
  logic [7:0]  mem_data;
  logic        mem_valid;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic        instr_valid;
  logic [2:0]  instr_fmt;
  logic [1:0]  instr_len;
  logic [7:0]  instr_opcode;
  logic [15:0] instr_operand;
  logic [11:0] instr_offset;
  logic [15:0] instr_pc;
  logic [15:0] instr_next_pc;
  logic [15:0] instr_target;

  int          errors = 0;
  int          checks = 0;
  bit          finished = 1'b0;
  bit          gaps = 1'b0;
  logic [7:0]  lfsr = 8'hA7;
  logic [7:0]  img [3];
  logic [15:0] base = 16'h0000;
  logic [15:0] exp_fetch = 16'h0000;
  logic [15:0] rel_a;

  always #10 clk = ~clk;

  // Program memory model: three image bytes placed at base, filler elsewhere.
  assign rel_a    = mem_addr - base;
  assign mem_data = (rel_a < 16'd3) ? img[rel_a[1:0]] : 8'h00;

  instr_fetch_seq u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .stall         (stall),
    .take_branch   (take_branch),
    .mem_data      (mem_data),
    .mem_valid     (mem_valid),
    .mem_addr      (mem_addr),
    .mem_rd        (mem_rd),
    .instr_valid   (instr_valid),
    .instr_fmt     (instr_fmt),
    .instr_len     (instr_len),
    .instr_opcode  (instr_opcode),
    .instr_operand (instr_operand),
    .instr_offset  (instr_offset),
    .instr_pc      (instr_pc),
    .instr_next_pc (instr_next_pc),
    .instr_target  (instr_target)
  );

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_fmt(input logic [7:0] b0);
    if (b0[7])              return 3'd3;
    if (b0[7:4] == 4'h4)    return 3'd4;
    if (b0[7:4] == 4'h1)    return 3'd1;
    if (b0[7:4] inside {4'h2, 4'h3}) return 3'd2;
    return 3'd0;
  endfunction

  function automatic logic [1:0] exp_len(input logic [2:0] f);
    case (f)
      3'd0:    return 2'd1;
      3'd4:    return 2'd3;
      default: return 2'd2;
    endcase
  endfunction

  // One cycle of fetching: choose memory-valid, then predict the accepted address.
  task automatic fetch_cycle();
    @(negedge clk);
    if (gaps) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_valid = lfsr[0] | lfsr[3];
    end else begin
      mem_valid = 1'b1;
    end
    if (mem_rd && mem_valid) begin
      check_eq("R3 fetch address of accepted byte (R10 gaps)", {16'h0, mem_addr}, {16'h0, exp_fetch});
      exp_fetch = exp_fetch + 16'd1;
    end
  endtask

  task automatic wait_valid(output bit got);
    got = 1'b0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (instr_valid) begin
        got = 1'b1;
        mem_valid = 1'b0;
        break;
      end
      if (gaps) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_valid = lfsr[0] | lfsr[3];
      end else begin
        mem_valid = 1'b1;
      end
      if (mem_rd && mem_valid) begin
        check_eq("R3 fetch address of accepted byte (R10 gaps)", {16'h0, mem_addr}, {16'h0, exp_fetch});
        exp_fetch = exp_fetch + 16'd1;
      end
    end
  endtask

  task automatic run_instr(input logic [7:0] b0, input logic [7:0] b1,
                           input logic [7:0] b2, input bit take);
    bit          got;
    logic [2:0]  f;
    logic [1:0]  l;
    logic [15:0] opnd;
    logic [11:0] ofs;
    logic [15:0] tgt;
    logic [15:0] nxt;
    logic [15:0] after;
    img[0] = b0; img[1] = b1; img[2] = b2;
    base = exp_fetch;
    take_branch = take;
    f = exp_fmt(b0);
    l = exp_len(f);
    opnd = (f == 3'd1 || f == 3'd2) ? {8'h00, b1} : (f == 3'd4) ? {b1, b2} : 16'h0000;
    ofs  = (f == 3'd3) ? {b0[3:0], b1} : 12'h000;
    tgt  = base + {{4{ofs[11]}}, ofs};
    nxt  = base + {14'h0, l};
    after = (take && f == 3'd3) ? tgt : nxt;
    wait_valid(got);
    check_eq("R4 bundle becomes valid", {31'h0, got}, 32'h1);
    if (got) begin
      check_eq("R2 format code", {29'h0, instr_fmt}, {29'h0, f});
      check_eq("R2 length", {30'h0, instr_len}, {30'h0, l});
      check_eq("R5 opcode", {24'h0, instr_opcode}, {24'h0, b0});
      check_eq("R5 operand", {16'h0, instr_operand}, {16'h0, opnd});
      check_eq("R5 offset", {20'h0, instr_offset}, {20'h0, ofs});
      check_eq("R4 instruction address", {16'h0, instr_pc}, {16'h0, base});
      check_eq("R6 next address", {16'h0, instr_next_pc}, {16'h0, nxt});
      check_eq("R6 fetch address while presented", {16'h0, mem_addr}, {16'h0, nxt});
      check_eq("R7 branch target", {16'h0, instr_target}, {16'h0, tgt});
      @(negedge clk);
      check_eq("R4 valid lasts one cycle", {31'h0, instr_valid}, 32'h0);
      if (f == 3'd3)
        check_eq("R7 resume address after relative", {16'h0, mem_addr}, {16'h0, after});
      else
        check_eq("R8 take_branch ignored for non-relative", {16'h0, mem_addr}, {16'h0, after});
    end
    exp_fetch = after;
    take_branch = 1'b0;
  endtask

  initial begin
    bit got;
    rst_n = 1'b0; stall = 1'b0; take_branch = 1'b0; mem_valid = 1'b0;
    img[0] = 8'h00; img[1] = 8'h00; img[2] = 8'h00;
    repeat (3) @(negedge clk);
    check_eq("R1 reset fetch address", {16'h0, mem_addr}, 32'h0);
    check_eq("R1 reset valid low", {31'h0, instr_valid}, 32'h0);
    check_eq("R1 reset read strobe", {31'h0, mem_rd}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1 address after release", {16'h0, mem_addr}, 32'h0);
    check_eq("R1 valid after release", {31'h0, instr_valid}, 32'h0);
    exp_fetch = 16'h0000;

    // Sweep all first-byte values, both branch-take settings, with valid gaps.
    gaps = 1'b1;
    for (int p = 0; p < 2; p++) begin
      for (int v = 0; v < 256; v++) begin
        logic [7:0] b0;
        b0 = 8'(v);
        run_instr(b0, 8'(v * 37 + 11 + p * 101), ~b0, b0[0] ^ p[0]);
      end
    end
    gaps = 1'b0;

    // Relative branch with a negative offset from low addresses wraps.
    run_instr(8'h8F, 8'hFF, 8'h00, 1'b1);
    run_instr(8'h98, 8'h00, 8'h00, 1'b1);
    run_instr(8'hF0, 8'h05, 8'h00, 1'b1);

    // Stall in the middle of a wide instruction, then a memory wait, then stall on the bundle.
    img[0] = 8'h42; img[1] = 8'hA1; img[2] = 8'h5C;
    base = exp_fetch;
    @(negedge clk); mem_valid = 1'b1;
    @(negedge clk);
    stall = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check_eq("R9 read strobe low during stall", {31'h0, mem_rd}, 32'h0);
      check_eq("R9 address held during stall", {16'h0, mem_addr}, {16'h0, base + 16'd1});
      check_eq("R9 no bundle during stall", {31'h0, instr_valid}, 32'h0);
    end
    stall = 1'b0; mem_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check_eq("R10 address held without memory-valid", {16'h0, mem_addr}, {16'h0, base + 16'd1});
    end
    mem_valid = 1'b1;
    got = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (instr_valid) begin got = 1'b1; break; end
    end
    check_eq("R4 wide bundle valid after stall", {31'h0, got}, 32'h1);
    stall = 1'b1; mem_valid = 1'b0; take_branch = 1'b1;
    @(negedge clk);
    check_eq("R9 bundle held valid under stall", {31'h0, instr_valid}, 32'h1);
    check_eq("R9 operand held under stall", {16'h0, instr_operand}, 32'hA15C);
    check_eq("R9 address held on bundle", {16'h0, mem_addr}, {16'h0, base + 16'd3});
    stall = 1'b0;
    @(negedge clk);
    check_eq("R4 valid drops after stall release", {31'h0, instr_valid}, 32'h0);
    check_eq("R8 wide instruction ignores take_branch", {16'h0, mem_addr}, {16'h0, base + 16'd3});
    take_branch = 1'b0;

    // Reset in the middle of an instruction.
    img[0] = 8'h45; img[1] = 8'h01; img[2] = 8'h02;
    base = base + 16'd3;
    mem_valid = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_eq("R1 mid-run reset address", {16'h0, mem_addr}, 32'h0);
    check_eq("R1 mid-run reset valid", {31'h0, instr_valid}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule